// File: doc/BRIEF.md
# Bus Master Security Filter

This block sits between a single bus master, for example a DMA engine, and the system interconnect. For each read or write the master issues, it looks up the address in a small built-in attribution table to classify the address as secure or nonsecure. It then either forwards the access downstream or rejects it on the spot. Two plain input pins set the configuration, and there is no software-visible register. One pin says whether the attached master is trusted. The other picks how a rejected access is answered.

A rejected access never reaches the downstream port. Depending on the response-select pin, it completes on the upstream port either with a bus error, or cleanly as read-as-zero / write-ignored. Every rejection sets a sticky interrupt, which stays asserted until a separate clear pin is driven high.

Both request ports and both response ports are valid/ready streams. A transfer happens on a clock edge where valid and ready are both high. A source that raises valid keeps it high, with its payload unchanged, until that edge. The upstream port takes one access at a time. Upstream request-ready is low from acceptance until the upstream response handshake completes. Back-pressure on the upstream response passes straight through to the downstream response-ready.

Top module: `bus_master_sec_filter`

## Requirements
- R1: After reset, `up_req_ready` is 1 and `irq`, `dn_req_valid` and `up_rsp_valid` are 0.
- R2: The address is classified by a table of four inclusive base/limit regions, each with a secure flag. The lowest-numbered matching region decides, and an address matching no region is nonsecure. `dn_nonsec` carries that classification (1 = nonsecure) for every forwarded access.
- R3: An access is rejected exactly when `cfg_master_ns` is 1 (1 = nonsecure master, 0 = secure master) and the address is classified secure. A rejected access never raises `dn_req_valid`.
- R4: With `cfg_rej_err` at 1, a rejected access gives `up_rsp_valid` with `up_rsp_err` = 1 and `up_rsp_rdata` = 0 in the cycle after acceptance.
- R5: With `cfg_rej_err` at 0, a rejected access gives `up_rsp_valid` with `up_rsp_err` = 0 and `up_rsp_rdata` = 0 in the cycle after acceptance. A rejected write is discarded.
- R6: An allowed access appears on the downstream request port in the cycle after acceptance, with the same address, write flag and write data. The upstream response carries the downstream read data and error in the same cycle as `dn_rsp_valid`.
- R7: Only one access is outstanding at a time. `up_req_ready` is 0 from the edge of acceptance until the edge on which the upstream response is taken.
- R8: `irq` goes to 1 in the cycle after a rejected access is accepted and stays at 1 until it is cleared.
- R9: `irq_clr` = 1 at an edge clears `irq`. If a rejection is accepted at the same edge, the rejection wins and `irq` stays at 1.
- R10: `cfg_master_ns` and `cfg_rej_err` are sampled at acceptance. Changing them while an access is in flight does not change that access.
- R11: While stalled, `dn_req_valid` and its payload hold steady until `dn_req_ready`, and a rejection response holds `up_rsp_valid` until `up_rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request ready |
| up_req_addr | input | AW | Upstream request address |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_wdata | input | DW | Upstream write data |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Upstream response ready |
| up_rsp_rdata | output | DW | Upstream read data |
| up_rsp_err | output | 1 | Upstream response error |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request ready |
| dn_req_addr | output | AW | Downstream address |
| dn_req_write | output | 1 | Downstream write flag |
| dn_req_wdata | output | DW | Downstream write data |
| dn_nonsec | output | 1 | Downstream security attribute, 1 = nonsecure |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_ready | output | 1 | Downstream response ready |
| dn_rsp_rdata | input | DW | Downstream read data |
| dn_rsp_err | input | 1 | Downstream response error |
| cfg_master_ns | input | 1 | 1 = master is nonsecure, 0 = secure |
| cfg_rej_err | input | 1 | 1 = rejected access returns error, 0 = read-zero/write-ignored |
| irq_clr | input | 1 | Clears the pending interrupt |
| irq | output | 1 | Pending rejection interrupt |

## Verification
The bench uses the default parameters: AW = 16 and DW = 32. The default table has region 0 at 0x0000–0x0FFF (secure), region 1 at 0x1000–0x1FFF (nonsecure), region 2 at 0x2000–0x2FFF (secure) and region 3 at 0x1800–0x37FF (secure). Region 3 overlaps region 1, so 0x1800 is decided by priority. Region 3 also extends past region 2, so 0x3000 is secure only through the last entry. 0x4000 falls in no region. With this table, both edges of a region, overlap priority and the unmatched default can all be reached from the ports. Downstream stalls, upstream response stalls and changes to the configuration pins during an access are driven in directed scenarios.

// File: rtl/bmsf_pkg.sv
package bmsf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FWD_REQ = 2'd1,
    ST_FWD_RSP = 2'd2,
    ST_REJ     = 2'd3
  } xact_state_e;

endpackage

// File: rtl/bmsf_attr_lookup.sv
module bmsf_attr_lookup #(
  parameter int AW   = 16,
  parameter int NREG = 4,
  parameter logic [NREG-1:0][AW-1:0] RGN_BASE = '0,
  parameter logic [NREG-1:0][AW-1:0] RGN_LIMIT = '0,
  parameter logic [NREG-1:0]         RGN_SEC = '0
) (
  input  logic [AW-1:0] addr,
  output logic          addr_ns
);

  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    assign hit[g] = (addr >= RGN_BASE[g]) && (addr <= RGN_LIMIT[g]);
  end

  // Walk downward so the lowest-numbered matching region is the last writer.
  always_comb begin
    addr_ns = 1'b1;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) addr_ns = ~RGN_SEC[i];
    end
  end

endmodule

// File: rtl/bmsf_irq_latch.sv
module bmsf_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);

  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o); // R8

  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_o); // R9

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !clr_i) |=> pend_o); // R8

endmodule

// File: rtl/bmsf_xact_ctrl.sv
module bmsf_xact_ctrl
  import bmsf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_req_valid,
  output logic          up_req_ready,
  input  logic [AW-1:0] up_req_addr,
  input  logic          up_req_write,
  input  logic [DW-1:0] up_req_wdata,
  output logic          up_rsp_valid,
  input  logic          up_rsp_ready,
  output logic [DW-1:0] up_rsp_rdata,
  output logic          up_rsp_err,
  output logic          dn_req_valid,
  input  logic          dn_req_ready,
  output logic [AW-1:0] dn_req_addr,
  output logic          dn_req_write,
  output logic [DW-1:0] dn_req_wdata,
  output logic          dn_nonsec,
  input  logic          dn_rsp_valid,
  output logic          dn_rsp_ready,
  input  logic [DW-1:0] dn_rsp_rdata,
  input  logic          dn_rsp_err,
  input  logic          cfg_master_ns,
  input  logic          cfg_rej_err,
  input  logic          addr_ns,
  output logic          rej_pulse
);

  xact_state_e   st_q, st_d;
  logic [AW-1:0] addr_q;
  logic          write_q;
  logic [DW-1:0] wdata_q;
  logic          ns_q;
  logic          err_sel_q;

  logic accept;
  logic reject;

  assign accept    = up_req_valid && up_req_ready;
  assign reject    = cfg_master_ns && !addr_ns;
  assign rej_pulse = accept && reject;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (accept) st_d = reject ? ST_REJ : ST_FWD_REQ;
      ST_FWD_REQ: if (dn_req_ready) st_d = ST_FWD_RSP;
      ST_FWD_RSP: if (dn_rsp_valid && up_rsp_ready) st_d = ST_IDLE;
      ST_REJ:     if (up_rsp_ready) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      write_q   <= 1'b0;
      wdata_q   <= '0;
      ns_q      <= 1'b1;
      err_sel_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        addr_q    <= up_req_addr;
        write_q   <= up_req_write;
        wdata_q   <= up_req_wdata;
        ns_q      <= addr_ns;
        err_sel_q <= cfg_rej_err;
      end
    end
  end

  assign up_req_ready = (st_q == ST_IDLE);
  assign dn_req_valid = (st_q == ST_FWD_REQ);
  assign dn_req_addr  = addr_q;
  assign dn_req_write = write_q;
  assign dn_req_wdata = wdata_q;
  assign dn_nonsec    = ns_q;
  assign dn_rsp_ready = (st_q == ST_FWD_RSP) && up_rsp_ready;

  always_comb begin
    up_rsp_valid = 1'b0;
    up_rsp_rdata = '0;
    up_rsp_err   = 1'b0;
    if (st_q == ST_REJ) begin
      up_rsp_valid = 1'b1;
      up_rsp_err   = err_sel_q;
    end else if (st_q == ST_FWD_RSP) begin
      up_rsp_valid = dn_rsp_valid;
      up_rsp_rdata = dn_rsp_rdata;
      up_rsp_err   = dn_rsp_err;
    end
  end

  AST_REJ_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    rej_pulse |=> (up_rsp_valid && !dn_req_valid)); // R3

  AST_REJ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_pulse && cfg_rej_err) |=> up_rsp_err); // R4

  AST_REJ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rej_pulse |=> (up_rsp_rdata == '0)); // R5

  AST_FWD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !reject) |=> dn_req_valid); // R6

  AST_ONE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !up_req_ready); // R7

  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && !dn_req_ready) |=>
      (dn_req_valid && $stable(dn_req_addr) && $stable(dn_req_wdata))); // R11

  AST_REJ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REJ && !up_rsp_ready) |=> (up_rsp_valid && $stable(up_rsp_err))); // R11

endmodule

// File: rtl/bus_master_sec_filter.sv
module bus_master_sec_filter #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int NREG = 4,
  parameter logic [NREG-1:0][AW-1:0] RGN_BASE  = '{16'h1800, 16'h2000, 16'h1000, 16'h0000},
  parameter logic [NREG-1:0][AW-1:0] RGN_LIMIT = '{16'h37FF, 16'h2FFF, 16'h1FFF, 16'h0FFF},
  parameter logic [NREG-1:0]         RGN_SEC   = 4'b1101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_req_valid,
  output logic          up_req_ready,
  input  logic [AW-1:0] up_req_addr,
  input  logic          up_req_write,
  input  logic [DW-1:0] up_req_wdata,
  output logic          up_rsp_valid,
  input  logic          up_rsp_ready,
  output logic [DW-1:0] up_rsp_rdata,
  output logic          up_rsp_err,
  output logic          dn_req_valid,
  input  logic          dn_req_ready,
  output logic [AW-1:0] dn_req_addr,
  output logic          dn_req_write,
  output logic [DW-1:0] dn_req_wdata,
  output logic          dn_nonsec,
  input  logic          dn_rsp_valid,
  output logic          dn_rsp_ready,
  input  logic [DW-1:0] dn_rsp_rdata,
  input  logic          dn_rsp_err,
  input  logic          cfg_master_ns,
  input  logic          cfg_rej_err,
  input  logic          irq_clr,
  output logic          irq
);

  logic addr_ns;
  logic rej_pulse;

  bmsf_attr_lookup #(
    .AW       (AW),
    .NREG     (NREG),
    .RGN_BASE (RGN_BASE),
    .RGN_LIMIT(RGN_LIMIT),
    .RGN_SEC  (RGN_SEC)
  ) u_lookup (
    .addr   (up_req_addr),
    .addr_ns(addr_ns)
  );

  bmsf_xact_ctrl #(
    .AW(AW),
    .DW(DW)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_req_valid (up_req_valid),
    .up_req_ready (up_req_ready),
    .up_req_addr  (up_req_addr),
    .up_req_write (up_req_write),
    .up_req_wdata (up_req_wdata),
    .up_rsp_valid (up_rsp_valid),
    .up_rsp_ready (up_rsp_ready),
    .up_rsp_rdata (up_rsp_rdata),
    .up_rsp_err   (up_rsp_err),
    .dn_req_valid (dn_req_valid),
    .dn_req_ready (dn_req_ready),
    .dn_req_addr  (dn_req_addr),
    .dn_req_write (dn_req_write),
    .dn_req_wdata (dn_req_wdata),
    .dn_nonsec    (dn_nonsec),
    .dn_rsp_valid (dn_rsp_valid),
    .dn_rsp_ready (dn_rsp_ready),
    .dn_rsp_rdata (dn_rsp_rdata),
    .dn_rsp_err   (dn_rsp_err),
    .cfg_master_ns(cfg_master_ns),
    .cfg_rej_err  (cfg_rej_err),
    .addr_ns      (addr_ns),
    .rej_pulse    (rej_pulse)
  );

  bmsf_irq_latch u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (rej_pulse),
    .clr_i (irq_clr),
    .pend_o(irq)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    up_req_ready |-> (!dn_req_valid && !up_rsp_valid)); // R1

endmodule

// File: tb/sim_bus_master_sec_filter.sv
module sim_bus_master_sec_filter;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          up_req_valid = 1'b0;
  logic          up_req_ready;
  logic [AW-1:0] up_req_addr = '0;
  logic          up_req_write = 1'b0;
  logic [DW-1:0] up_req_wdata = '0;
  logic          up_rsp_valid;
  logic          up_rsp_ready = 1'b1;
  logic [DW-1:0] up_rsp_rdata;
  logic          up_rsp_err;
  logic          dn_req_valid;
  logic          dn_req_ready = 1'b0;
  logic [AW-1:0] dn_req_addr;
  logic          dn_req_write;
  logic [DW-1:0] dn_req_wdata;
  logic          dn_nonsec;
  logic          dn_rsp_valid = 1'b0;
  logic          dn_rsp_ready;
  logic [DW-1:0] dn_rsp_rdata = '0;
  logic          dn_rsp_err = 1'b0;
  logic          cfg_master_ns = 1'b0;
  logic          cfg_rej_err = 1'b0;
  logic          irq_clr = 1'b0;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_master_sec_filter u0 (
    .clk(clk), .rst_n(rst_n),
    .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
    .up_req_addr(up_req_addr), .up_req_write(up_req_write), .up_req_wdata(up_req_wdata),
    .up_rsp_valid(up_rsp_valid), .up_rsp_ready(up_rsp_ready),
    .up_rsp_rdata(up_rsp_rdata), .up_rsp_err(up_rsp_err),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
    .dn_req_addr(dn_req_addr), .dn_req_write(dn_req_write), .dn_req_wdata(dn_req_wdata),
    .dn_nonsec(dn_nonsec),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_ready(dn_rsp_ready),
    .dn_rsp_rdata(dn_rsp_rdata), .dn_rsp_err(dn_rsp_err),
    .cfg_master_ns(cfg_master_ns), .cfg_rej_err(cfg_rej_err),
    .irq_clr(irq_clr), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One access. A rejection is expected when exp_rej is set. When flip_cfg is
  // set, both config pins invert right after acceptance (R10). When clr_same
  // is set, irq_clr is pulsed at the accepting edge (R9).
  task automatic xact(input string tag, input logic [AW-1:0] addr, input logic wr,
                      input logic [DW-1:0] wd, input bit exp_rej, input bit exp_err,
                      input bit exp_ns, input int req_stall, input int rsp_stall,
                      input int up_stall, input logic [DW-1:0] rd, input logic rerr,
                      input bit flip_cfg, input bit clr_same);
    @(negedge clk);
    up_req_valid = 1'b1;
    up_req_addr  = addr;
    up_req_write = wr;
    up_req_wdata = wd;
    if (clr_same) irq_clr = 1'b1;
    #1 chk("R7", {tag, " ready before accept"}, up_req_ready, 1);
    @(negedge clk);
    up_req_valid = 1'b0;
    irq_clr = 1'b0;
    if (flip_cfg) begin
      cfg_master_ns = ~cfg_master_ns;
      cfg_rej_err   = ~cfg_rej_err;
    end
    #1;
    chk("R7", {tag, " ready after accept"}, up_req_ready, 0);
    if (exp_rej) begin
      chk("R3", {tag, " no downstream"}, dn_req_valid, 0);
      chk("R4", {tag, " rsp valid"}, up_rsp_valid, 1);
      chk(exp_err ? "R4" : "R5", {tag, " rsp err"}, up_rsp_err, exp_err);
      chk("R5", {tag, " rsp data zero"}, up_rsp_rdata, 0);
      chk(clr_same ? "R9" : "R8", {tag, " irq set"}, irq, 1);
      if (up_stall > 0) begin
        up_rsp_ready = 1'b0;
        for (int i = 0; i < up_stall; i++) begin
          @(negedge clk); #1;
          chk("R11", {tag, " rsp held"}, up_rsp_valid, 1);
          chk("R11", {tag, " err held"}, up_rsp_err, exp_err);
          chk("R3", {tag, " no downstream while held"}, dn_req_valid, 0);
        end
        up_rsp_ready = 1'b1;
      end
      @(negedge clk); #1;
      chk("R7", {tag, " ready after rsp"}, up_req_ready, 1);
      chk("R3", {tag, " still no downstream"}, dn_req_valid, 0);
    end else begin
      chk("R6", {tag, " dn valid"}, dn_req_valid, 1);
      chk("R6", {tag, " dn addr"}, dn_req_addr, addr);
      chk("R6", {tag, " dn write"}, dn_req_write, wr);
      chk("R6", {tag, " dn wdata"}, dn_req_wdata, wd);
      chk("R2", {tag, " dn nonsec"}, dn_nonsec, exp_ns);
      for (int i = 0; i < req_stall; i++) begin
        @(negedge clk); #1;
        chk("R11", {tag, " dn valid held"}, dn_req_valid, 1);
        chk("R11", {tag, " dn addr held"}, dn_req_addr, addr);
      end
      dn_req_ready = 1'b1;
      @(negedge clk);
      dn_req_ready = 1'b0;
      #1 chk("R6", {tag, " dn valid drops"}, dn_req_valid, 0);
      for (int i = 0; i < rsp_stall; i++) begin
        chk("R6", {tag, " no early rsp"}, up_rsp_valid, 0);
        @(negedge clk); #1;
      end
      dn_rsp_valid = 1'b1;
      dn_rsp_rdata = rd;
      dn_rsp_err   = rerr;
      #1;
      chk("R6", {tag, " rsp valid"}, up_rsp_valid, 1);
      chk("R6", {tag, " rsp data"}, up_rsp_rdata, rd);
      chk("R6", {tag, " rsp err"}, up_rsp_err, rerr);
      chk("R6", {tag, " dn rsp ready"}, dn_rsp_ready, 1);
      @(negedge clk);
      dn_rsp_valid = 1'b0;
      #1 chk("R7", {tag, " ready after rsp"}, up_req_ready, 1);
    end
    if (flip_cfg) begin
      cfg_master_ns = ~cfg_master_ns;
      cfg_rej_err   = ~cfg_rej_err;
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "ready", up_req_ready, 1);
    chk("R1", "irq", irq, 0);
    chk("R1", "dn valid", dn_req_valid, 0);
    chk("R1", "rsp valid", up_rsp_valid, 0);
  endtask

  task automatic t_secure_master();
    cfg_master_ns = 1'b0;
    xact("sec r0", 16'h0100, 1'b0, 32'h0, 0, 0, 0, 0, 0, 0, 32'hCAFE_0001, 1'b0, 0, 0);
    xact("sec prio", 16'h1800, 1'b1, 32'h1234_5678, 0, 0, 1, 2, 1, 0, 32'h0, 1'b0, 0, 0);
    xact("sec r3", 16'h3000, 1'b0, 32'h0, 0, 0, 0, 1, 0, 0, 32'hBEEF_0002, 1'b1, 0, 0);
    xact("sec none", 16'h4000, 1'b0, 32'h0, 0, 0, 1, 0, 0, 0, 32'h0000_0003, 1'b0, 0, 0);
    chk("R8", "no irq for secure master", irq, 0);
  endtask

  task automatic t_ns_allowed();
    cfg_master_ns = 1'b1;
    xact("ns r1 base", 16'h1000, 1'b1, 32'hA5A5_A5A5, 0, 0, 1, 0, 0, 0, 32'h0, 1'b0, 0, 0);
    xact("ns prio", 16'h1FFF, 1'b0, 32'h0, 0, 0, 1, 3, 2, 0, 32'h7777_0000, 1'b0, 0, 0);
    xact("ns none", 16'h4000, 1'b0, 32'h0, 0, 0, 1, 0, 0, 0, 32'h0000_4444, 1'b1, 0, 0);
    chk("R8", "no irq for allowed ns", irq, 0);
  endtask

  task automatic t_reject_err();
    cfg_master_ns = 1'b1;
    cfg_rej_err   = 1'b1;
    xact("rej err r0", 16'h0FFF, 1'b0, 32'h0, 1, 1, 0, 0, 0, 0, 32'h0, 1'b0, 0, 0);
    xact("rej err r3", 16'h37FF, 1'b1, 32'hDEAD_BEEF, 1, 1, 0, 0, 0, 2, 32'h0, 1'b0, 0, 0);
  endtask

  task automatic t_reject_raz();
    cfg_master_ns = 1'b1;
    cfg_rej_err   = 1'b0;
    xact("rej raz r2", 16'h2000, 1'b0, 32'h0, 1, 0, 0, 0, 0, 0, 32'h0, 1'b0, 0, 0);
    xact("rej raz wr", 16'h2FFF, 1'b1, 32'h1111_2222, 1, 0, 0, 0, 0, 0, 32'h0, 1'b0, 0, 0);
  endtask

  task automatic t_irq_clear();
    @(negedge clk); #1 chk("R8", "irq sticky while idle", irq, 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    #1 chk("R9", "irq cleared", irq, 0);
  endtask

  task automatic t_irq_race();
    cfg_master_ns = 1'b1;
    cfg_rej_err   = 1'b1;
    xact("race", 16'h0200, 1'b0, 32'h0, 1, 1, 0, 0, 0, 0, 32'h0, 1'b0, 0, 1);
    chk("R9", "rejection beats clear", irq, 1);
    t_irq_clear();
  endtask

  task automatic t_cfg_midflight();
    // reject sampled with ns=1, err=1; pins flip to 0/0 after acceptance
    cfg_master_ns = 1'b1;
    cfg_rej_err   = 1'b1;
    xact("R10 rej", 16'h0300, 1'b0, 32'h0, 1, 1, 0, 0, 0, 1, 32'h0, 1'b0, 1, 0);
    // forward sampled with ns=0; pins flip to 1/1 after acceptance
    cfg_master_ns = 1'b0;
    cfg_rej_err   = 1'b0;
    xact("R10 fwd", 16'h0400, 1'b1, 32'h5555_AAAA, 0, 0, 0, 1, 1, 0, 32'h0, 1'b0, 1, 0);
    t_irq_clear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_secure_master();
    t_ns_allowed();
    t_reject_err();
    t_reject_raz();
    t_irq_clear();
    t_irq_race();
    t_cfg_midflight();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule